// File: doc/BRIEF.md
# Packed Register-Write Command Unpacker

This block sits behind a command-buffer fetcher and turns a stream of 32-bit command words into individual register writes. Words arrive in fixed groups of five: an index header followed by four data words. The header carries four 8-bit register indices, one per byte. Each index is widened into a full register byte address. The top index bit chooses one of two 512-byte register windows. The four resulting writes are then issued one after another on a valid/ready write port.

Slots that are only padding name a dummy register. The block drops these writes and they never reach the write port. The block also flags every accepted write whose address falls in the execute alias range. A downstream drawing engine uses this flag as its start trigger. While a packet's writes are being issued, the word input is held off, so a packet is always consumed completely before the next header is taken.

Top module: `reg_pack_unpacker`

## Requirements
- R1: A packet is five words. The first accepted word after reset, or after a finished packet, is the header. `in_ready` stays high while the five words are collected and goes low in the cycle after the fifth word is accepted.
- R2: Writes leave in lane order 0, 1, 2, 3. Lane n uses header bits [8n+7:8n] as its index and the (n+1)-th data word as its data.
- R3: An index with bit 7 clear maps to address 0x1C00 + index*4, which lies in 0x1C00..0x1DFF.
- R4: An index with bit 7 set maps to address 0x2C00 + (index & 0x7F)*4, which lies in 0x2C00..0x2DFF.
- R5: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` hold their values into the next cycle.
- R6: `in_ready` is low whenever a write is pending. It returns high in the cycle after the last lane of the packet is accepted or skipped.
- R7: A lane whose address is the padding register 0x1C54 (index 0x15) never raises `wr_valid`. The lane is skipped in one cycle.
- R8: `exec_pulse` is high for exactly the cycle after an accepted write whose address lies in 0x1D00..0x1DFF (indices 0x40..0x7F). It stays low otherwise, including for writes to 0x2D00..0x2DFF.
- R9: A synchronous reset discards a partly collected packet. The next accepted word is treated as a header.
- R10: In the cycle after reset, `in_ready` is 1, `wr_valid` is 0 and `exec_pulse` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Command word available |
| in_word | input | 32 | Command word |
| in_ready | output | 1 | Command word taken when high together with in_valid |
| wr_valid | output | 1 | Register write request |
| wr_addr | output | 16 | Register byte address |
| wr_data | output | 32 | Register write data |
| wr_ready | input | 1 | Write accepted when high together with wr_valid |
| exec_pulse | output | 1 | One-cycle flag after an accepted execute-alias write |

## Verification
The assertions assume that the write sink may hold `wr_ready` low for any number of cycles but eventually raises it. They also assume that `in_word` only matters in cycles where `in_valid` and `in_ready` are both high. The bench drives `wr_ready` from a fixed pattern that is either always high or high one cycle in three. It changes `in_valid` and `in_word` only away from the clock edge, and offers a word only while `in_ready` is seen high. Padding, both register windows, the edges of the execute range and a reset in the middle of a packet are each placed in known lanes, so the expected address order is fixed in advance.

// File: rtl/rpu_pkg.sv
package rpu_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 16;
    localparam int IDX_W  = 8;
    localparam int LANES  = 4;
    localparam int LANE_W = $clog2(LANES);
    localparam int CNT_W  = $clog2(LANES + 1);

    localparam logic [ADDR_W-1:0] WIN0_BASE = 16'h1C00;
    localparam logic [ADDR_W-1:0] WIN1_BASE = 16'h2C00;
    localparam logic [ADDR_W-1:0] PAD_ADDR  = 16'h1C54;
    localparam logic [ADDR_W-1:0] EXEC_LO   = 16'h1D00;
    localparam logic [ADDR_W-1:0] EXEC_HI   = 16'h1DFF;

    typedef enum logic {
        PH_GATHER = 1'b0,
        PH_ISSUE  = 1'b1
    } phase_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              skip;
        logic              kick;
    } lane_t;

    function automatic logic [ADDR_W-1:0] idx_to_addr(input logic [IDX_W-1:0] idx);
        logic [ADDR_W-1:0] off;
        off = '0;
        off[IDX_W:0] = {idx[IDX_W-2:0], 2'b00};
        return (idx[IDX_W-1] ? WIN1_BASE : WIN0_BASE) + off;
    endfunction

    function automatic logic is_pad(input logic [ADDR_W-1:0] a);
        return a == PAD_ADDR;
    endfunction

    function automatic logic is_exec(input logic [ADDR_W-1:0] a);
        return (a >= EXEC_LO) && (a <= EXEC_HI);
    endfunction

endpackage

// File: rtl/rpu_collector.sv
module rpu_collector
    import rpu_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          take,
    input  logic [DATA_W-1:0]             word,
    output logic [DATA_W-1:0]             hdr,
    output logic [LANES-1:0][DATA_W-1:0]  payload,
    output logic                          pkt_done
);
    logic [CNT_W-1:0]  cnt_q;
    logic [LANE_W-1:0] slot;

    assign slot     = LANE_W'(cnt_q - CNT_W'(1));
    assign pkt_done = take && (cnt_q == CNT_W'(LANES));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (take) begin
            cnt_q <= (cnt_q == CNT_W'(LANES)) ? '0 : cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (take) begin
            if (cnt_q == '0) hdr <= word;
            else             payload[slot] <= word;
        end
    end
endmodule

// File: rtl/rpu_lane_decode.sv
module rpu_lane_decode
    import rpu_pkg::*;
(
    input  logic [DATA_W-1:0]             hdr,
    input  logic [LANES-1:0][DATA_W-1:0]  payload,
    output lane_t [LANES-1:0]             lanes
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [IDX_W-1:0] idx;
        lane_t            ln;
        assign idx     = hdr[g*IDX_W +: IDX_W];
        assign ln.addr = idx_to_addr(idx);
        assign ln.data = payload[g];
        assign ln.skip = is_pad(ln.addr);
        assign ln.kick = is_exec(ln.addr);
        assign lanes[g] = ln;
    end
endmodule

// File: rtl/rpu_issuer.sv
module rpu_issuer
    import rpu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pkt_done,
    input  lane_t [LANES-1:0] lanes,
    output logic              in_ready,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    input  logic              wr_ready,
    output logic              exec_pulse
);
    phase_e            phase_q;
    logic [LANE_W-1:0] lane_q;
    lane_t             cur;
    logic              busy;
    logic              step;
    logic              last;

    assign cur      = lanes[lane_q];
    assign busy     = (phase_q == PH_ISSUE);
    assign in_ready = !busy;
    assign wr_valid = busy && !cur.skip;
    assign wr_addr  = cur.addr;
    assign wr_data  = cur.data;
    assign step     = busy && (cur.skip || wr_ready);
    assign last     = (lane_q == LANE_W'(LANES - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q    <= PH_GATHER;
            lane_q     <= '0;
            exec_pulse <= 1'b0;
        end else begin
            exec_pulse <= wr_valid && wr_ready && cur.kick;
            if (!busy) begin
                if (pkt_done) begin
                    phase_q <= PH_ISSUE;
                    lane_q  <= '0;
                end
            end else if (step) begin
                if (last) begin
                    phase_q <= PH_GATHER;
                    lane_q  <= '0;
                end else begin
                    lane_q <= lane_q + LANE_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/reg_pack_unpacker.sv
module reg_pack_unpacker
    import rpu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [31:0]       in_word,
    output logic              in_ready,
    output logic              wr_valid,
    output logic [15:0]       wr_addr,
    output logic [31:0]       wr_data,
    input  logic              wr_ready,
    output logic              exec_pulse
);
    logic [DATA_W-1:0]            hdr;
    logic [LANES-1:0][DATA_W-1:0] payload;
    logic                         pkt_done;
    lane_t [LANES-1:0]            lanes;

    rpu_collector u_collect (
        .clk      (clk),
        .rst      (rst),
        .take     (in_valid && in_ready),
        .word     (in_word),
        .hdr      (hdr),
        .payload  (payload),
        .pkt_done (pkt_done)
    );

    rpu_lane_decode u_decode (
        .hdr     (hdr),
        .payload (payload),
        .lanes   (lanes)
    );

    rpu_issuer u_issue (
        .clk        (clk),
        .rst        (rst),
        .pkt_done   (pkt_done),
        .lanes      (lanes),
        .in_ready   (in_ready),
        .wr_valid   (wr_valid),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .wr_ready   (wr_ready),
        .exec_pulse (exec_pulse)
    );
endmodule

// File: rtl/rpu_checker.sv
module rpu_checker (
    input logic        clk,
    input logic        rst,
    input logic        in_ready,
    input logic        wr_valid,
    input logic [15:0] wr_addr,
    input logic [31:0] wr_data,
    input logic        wr_ready,
    input logic        exec_pulse
);
    AST_STALL_WHILE_ISSUE: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> !in_ready); // R6

    AST_HOLD_UNDER_BACKPRESSURE: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data))); // R5

    AST_PAD_NEVER_ISSUED: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> (wr_addr != 16'h1C54)); // R7

    AST_ADDR_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> ((wr_addr[1:0] == 2'b00) &&
                      (((wr_addr >= 16'h1C00) && (wr_addr <= 16'h1DFF)) ||
                       ((wr_addr >= 16'h2C00) && (wr_addr <= 16'h2DFF))))); // R3

    AST_EXEC_AFTER_ALIAS_WRITE: assert property (@(posedge clk) disable iff (rst)
        exec_pulse |-> ($past(wr_valid && wr_ready) &&
                        ($past(wr_addr) >= 16'h1D00) && ($past(wr_addr) <= 16'h1DFF))); // R8

    AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (in_ready && !wr_valid && !exec_pulse)); // R10
endmodule

bind reg_pack_unpacker rpu_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_ready   (in_ready),
    .wr_valid   (wr_valid),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .wr_ready   (wr_ready),
    .exec_pulse (exec_pulse)
);

// File: tb/tb_reg_pack_unpacker.sv
module tb_reg_pack_unpacker;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic        in_ready;
    logic        wr_valid;
    logic [15:0] wr_addr;
    logic [31:0] wr_data;
    logic        wr_ready = 1'b1;
    logic        exec_pulse;

    reg_pack_unpacker dut (.*);

    always #5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int slow_ready = 0;

    logic [15:0] cap_addr [16];
    logic [31:0] cap_data [16];
    int cap_n = 0;
    int exec_n = 0;
    int exec_err = 0;
    int hold_err = 0;
    logic prev_acc_exec = 1'b0;
    logic prev_stall = 1'b0;
    logic [15:0] prev_addr = '0;
    logic [31:0] prev_data = '0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        wr_ready <= (slow_ready == 0) ? 1'b1 : ((cyc % 3) == 0);
        if (cyc > 20000) begin
            fails = fails + 1;
            $display("FAIL watchdog expired act=%0d exp<=20000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    // Monitor: capture accepted writes, check hold and exec timing.
    always @(negedge clk) begin
        if (rst) begin
            prev_acc_exec = 1'b0;
            prev_stall    = 1'b0;
        end else begin
            if (exec_pulse !== prev_acc_exec) exec_err = exec_err + 1;
            if (exec_pulse) exec_n = exec_n + 1;
            if (prev_stall && !(wr_valid && wr_addr == prev_addr && wr_data == prev_data))
                hold_err = hold_err + 1;
            prev_acc_exec = wr_valid && wr_ready && wr_addr >= 16'h1D00 && wr_addr <= 16'h1DFF;
            prev_stall    = wr_valid && !wr_ready;
            prev_addr     = wr_addr;
            prev_data     = wr_data;
            if (wr_valid && wr_ready && cap_n < 16) begin
                cap_addr[cap_n] = wr_addr;
                cap_data[cap_n] = wr_data;
                cap_n = cap_n + 1;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_addr(input logic [7:0] idx);
        if (idx[7]) return 16'h2C00 + {7'd0, idx[6:0], 2'b00};
        else        return 16'h1C00 + {7'd0, idx[6:0], 2'b00};
    endfunction

    task automatic push(input logic [31:0] w);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_word  = w;
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    task automatic clear_log();
        cap_n = 0; exec_n = 0; exec_err = 0; hold_err = 0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (in_ready && !wr_valid) break;
        end
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(in_ready === 1'b1, "R10 in_ready after reset", in_ready, 1);
        check(wr_valid === 1'b0, "R10 wr_valid after reset", wr_valid, 0);
        check(exec_pulse === 1'b0, "R10 exec_pulse after reset", exec_pulse, 0);
    endtask

    task automatic t_basic_order();
        logic [31:0] hdr;
        logic [31:0] d [4];
        hdr = 32'h8A_7F_40_03;
        d[0] = 32'h1111_0001; d[1] = 32'h2222_0002; d[2] = 32'h3333_0003; d[3] = 32'h4444_0004;
        slow_ready = 0;
        clear_log();
        push(hdr);
        for (int i = 0; i < 3; i++) push(d[i]);
        @(negedge clk);
        check(in_ready === 1'b1, "R1 in_ready before fifth word", in_ready, 1);
        push(d[3]);
        @(negedge clk);
        check(in_ready === 1'b0, "R1 R6 in_ready low after fifth word", in_ready, 0);
        wait_idle();
        check(cap_n == 4, "R2 write count", cap_n, 4);
        for (int i = 0; i < 4; i++) begin
            check(cap_addr[i] == exp_addr(hdr[8*i +: 8]), "R2 R3 R4 lane address", cap_addr[i], exp_addr(hdr[8*i +: 8]));
            check(cap_data[i] == d[i], "R2 lane data", cap_data[i], d[i]);
        end
        check(cap_addr[1] == 16'h1D00, "R3 low edge of exec range", cap_addr[1], 16'h1D00);
        check(cap_addr[3] == 16'h2C28, "R4 upper window address", cap_addr[3], 16'h2C28);
        check(exec_n == 2, "R8 exec pulse count", exec_n, 2);
        check(exec_err == 0, "R8 exec pulse timing", exec_err, 0);
        check(in_ready === 1'b1, "R6 in_ready back high", in_ready, 1);
    endtask

    task automatic t_backpressure_pad();
        logic [31:0] hdr;
        hdr = 32'hFF_80_15_41;
        slow_ready = 1;
        clear_log();
        push(hdr);
        for (int i = 0; i < 4; i++) push(32'hA0A0_0000 + i);
        wait_idle();
        slow_ready = 0;
        check(cap_n == 3, "R7 pad lane dropped", cap_n, 3);
        check(cap_addr[0] == 16'h1D04, "R2 lane0 under backpressure", cap_addr[0], 16'h1D04);
        check(cap_data[1] == 32'hA0A0_0002, "R7 lane2 follows pad", cap_data[1], 32'hA0A0_0002);
        check(cap_addr[1] == 16'h2C00, "R4 window base", cap_addr[1], 16'h2C00);
        check(cap_addr[2] == 16'h2DFC, "R4 window top", cap_addr[2], 16'h2DFC);
        check(hold_err == 0, "R5 hold while not ready", hold_err, 0);
        check(exec_n == 1, "R8 no exec for upper window", exec_n, 1);
        check(exec_err == 0, "R8 exec timing under backpressure", exec_err, 0);
    endtask

    task automatic t_all_pad();
        clear_log();
        push(32'h15151515);
        for (int i = 0; i < 4; i++) push(32'h5555_0000 + i);
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        check(in_ready === 1'b0, "R7 four skip cycles", in_ready, 0);
        @(negedge clk);
        check(in_ready === 1'b1, "R6 R7 ready after skipped lanes", in_ready, 1);
        check(cap_n == 0, "R7 no writes for padding", cap_n, 0);
    endtask

    task automatic t_reset_partial();
        push(32'h01010101);
        push(32'hDEAD_BEEF);
        do_reset();
        clear_log();
        push(32'h04_03_02_01);
        for (int i = 0; i < 4; i++) push(32'hC0DE_0010 + i);
        wait_idle();
        check(cap_n == 4, "R9 full packet after reset", cap_n, 4);
        for (int i = 0; i < 4; i++) begin
            check(cap_addr[i] == 16'h1C04 + 16'(4 * i), "R9 address realigned", cap_addr[i], 16'h1C04 + 16'(4 * i));
            check(cap_data[i] == 32'hC0DE_0010 + i, "R9 data realigned", cap_data[i], 32'hC0DE_0010 + i);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset_state();
        t_basic_order();
        t_backpressure_pad();
        t_all_pad();
        t_reset_partial();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule